// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block looks up a translation in a hashed page table held in an external synchronous memory. A request carries a virtual page number and a flag that says whether the page is large. From these the block forms an XOR hash and masks it into a group index. Each group holds eight entries. The block reads the entries of that group one per cycle and compares each one against the request. If nothing in the primary group matches, it probes a secondary group in the same way.

When an entry matches, the block reports a one-cycle result. The result gives the slot, whether the secondary group supplied it, the real page number and the protection fields. If all sixteen candidates fail, it reports a miss instead. A request is taken only while the block is idle. The hash mask is sampled together with the request, so software can size the table without changing the hardware.

Each memory entry is two 64-bit words, with the second word in the upper half. The memory port issues one read at a time and returns the data one cycle after the request.

Top module: `hpt_group_search`

## Requirements
- R1: After synchronous reset, `done_o`, `hit_o`, `miss_o` and `mem_req_o` are all 0.
- R2: For a small page (`req_large_i`=0), the primary group is `(vpn[54:16] ^ {23'b0, vpn[15:0]})[GRP_W-1:0] & mask`. The memory address of a read is `{group, slot[2:0]}`.
- R3: For a large page (`req_large_i`=1), the segment part is `vpn >> 4`, and its low 39 bits are XORed with `vpn[3:0]`. The primary group is masked from that hash in the same way as R2.
- R4: Reads go out one per cycle with at most one outstanding. Primary slots 0 to 7 are read first, then secondary slots 0 to 7. The secondary group is `~hash[GRP_W-1:0] & mask`.
- R5: An entry matches only when all four of these hold:
  - bit 0 of word 0 (valid) is 1;
  - bit 1 (hash identifier) is 0 in the primary probe or 1 in the secondary probe;
  - bit 2 (large) equals `req_large_i`;
  - bits 63:7 equal `vpn[63:7]`.
- R6: When several entries match, the first one in read order is reported.
- R7: On a hit, `done_o` and `hit_o` are high for exactly one cycle, and the outputs are set as follows:
  - `slot_o` is the slot and `sec_o` marks the secondary group;
  - `rpn_o` is word 1 bits 61:12;
  - `pp_o` is word 1 bits 1:0;
  - `nx_o` is word 1 bit 2.
  The result appears two cycles after the read of the matching entry is issued.
- R8: When all 16 candidates fail, `done_o` and `miss_o` are high for one cycle with `hit_o`=0, after exactly 16 reads.
- R9: A request presented while a search is running is ignored and does not change that search's result.
- R10: No read is issued after the matching entry has been returned. A hit at read position k (0 to 15) costs exactly k+1 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Starts a search when the block is idle |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_large_i | input | 1 | 1 selects the large page hash split |
| hash_mask_i | input | GRP_W | Mask applied to the hash to form group indices |
| mem_req_o | output | 1 | Read request to the entry memory |
| mem_addr_o | output | GRP_W+3 | Entry address {group, slot} |
| mem_rvalid_i | input | 1 | Read data valid, one cycle after the request |
| mem_rdata_i | input | AVPN_W+RPN_W+21 | Entry, word 1 above word 0 |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Completion found a match |
| miss_o | output | 1 | Completion found no match |
| slot_o | output | 3 | Slot of the matching entry |
| sec_o | output | 1 | Match came from the secondary group |
| rpn_o | output | RPN_W | Real page number of the match |
| pp_o | output | 2 | Protection field of the match |
| nx_o | output | 1 | No-execute bit of the match |

## Verification
The hardest case to reach from the ports is a primary group full of near-miss entries. Each of these differs from the request in exactly one of valid, hash identifier, page size or abbreviated page number, and the real match then lies deep in the secondary group. The bench places such decoys directly in its memory model at addresses it computes from its own hash. It then checks the slot reported and the full sequence of addresses read. A second hard case is a request that arrives mid-search. The bench pulses a competing request whose own entry would hit sooner, and confirms that the first search's result is the one delivered.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int SLOTS   = 8;
  localparam int SLOT_W  = 3;
  localparam int PROBES  = 2 * SLOTS;

  // Word 0 field positions (decoded by the memory image producer as well)
  localparam int W0_VALID = 0;
  localparam int W0_HID   = 1;
  localparam int W0_LARGE = 2;
  localparam int W0_ABBR  = 7;

  // Word 1 field positions
  localparam int W1_PP    = 0;
  localparam int W1_NX    = 2;
  localparam int W1_RPN   = 12;

  typedef enum logic {ST_IDLE, ST_RUN} hpt_state_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W       = 64,
  parameter int HASH_W      = 39,
  parameter int GRP_W       = 11,
  parameter int SMALL_SHIFT = 16,
  parameter int LARGE_SHIFT = 4
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic             large_i,
  input  logic [GRP_W-1:0] mask_i,
  output logic [GRP_W-1:0] grp_pri_o,
  output logic [GRP_W-1:0] grp_sec_o
);
  localparam logic [VPN_W-1:0] ONES = {VPN_W{1'b1}};

  logic [VPN_W-1:0]  seg_small, seg_large, pg_small, pg_large;
  logic [VPN_W-1:0]  seg, pg;
  logic [HASH_W-1:0] hash;

  assign seg_small = vpn_i >> SMALL_SHIFT;
  assign seg_large = vpn_i >> LARGE_SHIFT;
  assign pg_small  = vpn_i & (ONES >> (VPN_W - SMALL_SHIFT));
  assign pg_large  = vpn_i & (ONES >> (VPN_W - LARGE_SHIFT));

  assign seg = large_i ? seg_large : seg_small;
  assign pg  = large_i ? pg_large  : pg_small;

  assign hash      = seg[HASH_W-1:0] ^ pg[HASH_W-1:0];
  assign grp_pri_o = hash[GRP_W-1:0] & mask_i;
  assign grp_sec_o = ~hash[GRP_W-1:0] & mask_i;
endmodule

// File: rtl/hpt_entry_cmp.sv
module hpt_entry_cmp
  import hpt_pkg::*;
#(
  parameter int AVPN_W = 57,
  parameter int RPN_W  = 50
) (
  input  logic [AVPN_W+RPN_W+20:0] entry_i,
  input  logic [AVPN_W-1:0]        want_abbr_i,
  input  logic                     want_large_i,
  input  logic                     want_hid_i,
  output logic                     match_o,
  output logic [RPN_W-1:0]         rpn_o,
  output logic [1:0]               pp_o,
  output logic                     nx_o
);
  localparam int W0_W = AVPN_W + 7;
  localparam int W1_W = RPN_W + 14;

  logic [W0_W-1:0] w0;
  logic [W1_W-1:0] w1;

  assign w0 = entry_i[W0_W-1:0];
  assign w1 = entry_i[W0_W +: W1_W];

  assign match_o = w0[W0_VALID]
                 && (w0[W0_HID] == want_hid_i)
                 && (w0[W0_LARGE] == want_large_i)
                 && (w0[W0_ABBR +: AVPN_W] == want_abbr_i);

  assign rpn_o = w1[W1_RPN +: RPN_W];
  assign pp_o  = w1[W1_PP +: 2];
  assign nx_o  = w1[W1_NX];
endmodule

// File: rtl/hpt_seq.sv
module hpt_seq
  import hpt_pkg::*;
#(
  parameter int VPN_W  = 64,
  parameter int AVPN_W = 57,
  parameter int RPN_W  = 50,
  parameter int GRP_W  = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid_i,
  input  logic [VPN_W-1:0]        req_vpn_i,
  input  logic                    req_large_i,
  input  logic [GRP_W-1:0]        grp_pri_i,
  input  logic [GRP_W-1:0]        grp_sec_i,
  output logic                    mem_req_o,
  output logic [GRP_W+SLOT_W-1:0] mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic                    match_i,
  input  logic [RPN_W-1:0]        rpn_i,
  input  logic [1:0]              pp_i,
  input  logic                    nx_i,
  output logic [AVPN_W-1:0]       want_abbr_o,
  output logic                    want_large_o,
  output logic                    want_hid_o,
  output logic                    done_o,
  output logic                    hit_o,
  output logic                    miss_o,
  output logic [SLOT_W-1:0]       slot_o,
  output logic                    sec_o,
  output logic [RPN_W-1:0]        rpn_o,
  output logic [1:0]              pp_o,
  output logic                    nx_o
);
  localparam int CNT_W = SLOT_W + 2;
  localparam int IDX_W = SLOT_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PROBES - 1);

  hpt_state_e       state;
  logic [CNT_W-1:0] iss_idx;
  logic [IDX_W-1:0] chk_idx;
  logic             pend;
  logic [GRP_W-1:0] gp_q, gs_q;
  logic             issue;
  logic             finish_hit;

  assign finish_hit = mem_rvalid_i && match_i;
  assign issue = (state == ST_RUN) && !iss_idx[CNT_W-1]
               && (!pend || mem_rvalid_i) && !finish_hit;

  assign mem_req_o  = issue;
  assign mem_addr_o = {(iss_idx[SLOT_W] ? gs_q : gp_q), iss_idx[SLOT_W-1:0]};
  assign want_hid_o = chk_idx[SLOT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      iss_idx      <= '0;
      chk_idx      <= '0;
      pend         <= 1'b0;
      gp_q         <= '0;
      gs_q         <= '0;
      want_abbr_o  <= '0;
      want_large_o <= 1'b0;
      done_o       <= 1'b0;
      hit_o        <= 1'b0;
      miss_o       <= 1'b0;
      slot_o       <= '0;
      sec_o        <= 1'b0;
      rpn_o        <= '0;
      pp_o         <= '0;
      nx_o         <= 1'b0;
    end else begin
      done_o <= 1'b0;
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid_i) begin
            state        <= ST_RUN;
            iss_idx      <= '0;
            chk_idx      <= '0;
            pend         <= 1'b0;
            gp_q         <= grp_pri_i;
            gs_q         <= grp_sec_i;
            want_abbr_o  <= req_vpn_i[VPN_W-1 -: AVPN_W];
            want_large_o <= req_large_i;
          end
        end
        default: begin
          if (issue) begin
            iss_idx <= iss_idx + 1'b1;
            pend    <= 1'b1;
          end else if (mem_rvalid_i) begin
            pend <= 1'b0;
          end
          if (mem_rvalid_i) begin
            chk_idx <= chk_idx + 1'b1;
            if (match_i) begin
              state  <= ST_IDLE;
              pend   <= 1'b0;
              done_o <= 1'b1;
              hit_o  <= 1'b1;
              slot_o <= chk_idx[SLOT_W-1:0];
              sec_o  <= chk_idx[SLOT_W];
              rpn_o  <= rpn_i;
              pp_o   <= pp_i;
              nx_o   <= nx_i;
            end else if (chk_idx == LAST_IDX) begin
              state  <= ST_IDLE;
              pend   <= 1'b0;
              done_o <= 1'b1;
              miss_o <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: each completion is exactly one of hit or miss
  assert_result_excl_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (hit_o ^ miss_o));

  // R4: back-to-back reads walk the slots in ascending order
  assert_slot_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && $past(mem_req_o)) |->
      (mem_addr_o[SLOT_W-1:0] == $past(mem_addr_o[SLOT_W-1:0]) + 1'b1));

  // R4: never more than one read outstanding
  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (rst)
    (pend && !mem_rvalid_i) |-> !mem_req_o);

  // R10: the port is quiet once a result is delivered
  assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mem_req_o);
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
  import hpt_pkg::*;
#(
  parameter int VPN_W  = 64,
  parameter int AVPN_W = 57,
  parameter int RPN_W  = 50,
  parameter int HASH_W = 39,
  parameter int GRP_W  = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid_i,
  input  logic [VPN_W-1:0]         req_vpn_i,
  input  logic                     req_large_i,
  input  logic [GRP_W-1:0]         hash_mask_i,
  output logic                     mem_req_o,
  output logic [GRP_W+2:0]         mem_addr_o,
  input  logic                     mem_rvalid_i,
  input  logic [AVPN_W+RPN_W+20:0] mem_rdata_i,
  output logic                     done_o,
  output logic                     hit_o,
  output logic                     miss_o,
  output logic [2:0]               slot_o,
  output logic                     sec_o,
  output logic [RPN_W-1:0]         rpn_o,
  output logic [1:0]               pp_o,
  output logic                     nx_o
);
  logic [GRP_W-1:0]  grp_pri, grp_sec;
  logic [AVPN_W-1:0] want_abbr;
  logic              want_large, want_hid;
  logic              match;
  logic [RPN_W-1:0]  ent_rpn;
  logic [1:0]        ent_pp;
  logic              ent_nx;

  hpt_hash #(
    .VPN_W(VPN_W), .HASH_W(HASH_W), .GRP_W(GRP_W),
    .SMALL_SHIFT(16), .LARGE_SHIFT(4)
  ) u_hash (
    .vpn_i    (req_vpn_i),
    .large_i  (req_large_i),
    .mask_i   (hash_mask_i),
    .grp_pri_o(grp_pri),
    .grp_sec_o(grp_sec)
  );

  hpt_entry_cmp #(.AVPN_W(AVPN_W), .RPN_W(RPN_W)) u_cmp (
    .entry_i     (mem_rdata_i),
    .want_abbr_i (want_abbr),
    .want_large_i(want_large),
    .want_hid_i  (want_hid),
    .match_o     (match),
    .rpn_o       (ent_rpn),
    .pp_o        (ent_pp),
    .nx_o        (ent_nx)
  );

  hpt_seq #(
    .VPN_W(VPN_W), .AVPN_W(AVPN_W), .RPN_W(RPN_W), .GRP_W(GRP_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_vpn_i   (req_vpn_i),
    .req_large_i (req_large_i),
    .grp_pri_i   (grp_pri),
    .grp_sec_i   (grp_sec),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .match_i     (match),
    .rpn_i       (ent_rpn),
    .pp_i        (ent_pp),
    .nx_i        (ent_nx),
    .want_abbr_o (want_abbr),
    .want_large_o(want_large),
    .want_hid_o  (want_hid),
    .done_o      (done_o),
    .hit_o       (hit_o),
    .miss_o      (miss_o),
    .slot_o      (slot_o),
    .sec_o       (sec_o),
    .rpn_o       (rpn_o),
    .pp_o        (pp_o),
    .nx_o        (nx_o)
  );
endmodule

// File: tb/hpt_group_search_tb.sv
module hpt_group_search_tb;
  localparam int VW = 64;
  localparam int AW = 57;
  localparam int RW = 50;
  localparam int GW = 6;
  localparam int AD = GW + 3;
  localparam int EW = AW + RW + 21;
  localparam int NV = 8;

  // vector table: vpn, large, mask, read position of the match (16 = none)
  localparam logic [63:0] TV_VPN [NV] = '{
    64'h0000_1234_5678_9ABC, 64'h0ABC_0000_0003_0005, 64'h0000_0000_00F0_0A5C,
    64'h7700_0000_4321_0F0F, 64'h0001_0000_0000_ABCD, 64'h0000_0000_0099_1111,
    64'h1111_2222_3333_4444, 64'h0000_0000_0000_0123};
  localparam logic [NV-1:0] TV_LARGE = 8'b1001_0100;
  localparam logic [GW-1:0] TV_MASK [NV] = '{6'h3F, 6'h3F, 6'h1F, 6'h3F, 6'h3F, 6'h00, 6'h3F, 6'h0F};
  localparam int TV_POS [NV] = '{0, 7, 3, 9, 15, 12, 16, 16};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [VW-1:0] req_vpn = '0;
  logic req_large = 1'b0;
  logic [GW-1:0] hash_mask = '0;
  logic mem_req;
  logic [AD-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [EW-1:0] mem_rdata = '0;
  logic done, hit, miss, sec, nx;
  logic [2:0] slot;
  logic [RW-1:0] rpn;
  logic [1:0] pp;

  logic [EW-1:0] mem [1 << AD];
  logic [AD-1:0] rd_log [64];
  int rd_cnt = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  hpt_group_search #(.VPN_W(VW), .AVPN_W(AW), .RPN_W(RW), .HASH_W(39), .GRP_W(GW)) u_dut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_vpn_i(req_vpn),
    .req_large_i(req_large), .hash_mask_i(hash_mask), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .hit_o(hit), .miss_o(miss), .slot_o(slot), .sec_o(sec),
    .rpn_o(rpn), .pp_o(pp), .nx_o(nx));

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    if (mem_req) begin
      mem_rdata <= mem[mem_addr];
      rd_log[rd_cnt % 64] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [GW-1:0] grp(input logic [63:0] v, input logic lg,
                                        input logic [GW-1:0] m, input logic s);
    logic [63:0] sg, pg;
    logic [38:0] h;
    sg = lg ? (v >> 4) : (v >> 16);
    pg = lg ? (v & 64'hF) : (v & 64'hFFFF);
    h = sg[38:0] ^ pg[38:0];
    return s ? (~h[GW-1:0] & m) : (h[GW-1:0] & m);
  endfunction

  function automatic logic [EW-1:0] mk_ent(input logic [AW-1:0] abbr, input logic lg,
                                           input logic hid, input logic v,
                                           input logic [RW-1:0] r, input logic n,
                                           input logic [1:0] p);
    logic [63:0] w0, w1;
    w0 = {abbr, 2'b00, 1'b0, 1'b0, lg, hid, v};
    w1 = {1'b0, 1'b0, r, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, n, p};
    return {w1, w0};
  endfunction

  function automatic logic [AD-1:0] loc(input logic [63:0] v, input logic lg,
                                        input logic [GW-1:0] m, input int pos);
    logic [2:0] s3;
    s3 = pos[2:0];
    return {grp(v, lg, m, pos >= 8), s3};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < (1 << AD); i++) mem[i] = '0;
  endtask

  task automatic put(input logic [63:0] v, input logic lg, input logic [GW-1:0] m,
                     input int pos, input logic [RW-1:0] r, input logic n, input logic [1:0] p);
    mem[loc(v, lg, m, pos)] = mk_ent(v[63:7], lg, pos >= 8, 1'b1, r, n, p);
  endtask

  task automatic search(input logic [63:0] v, input logic lg, input logic [GW-1:0] m,
                        output int lat, output int base);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v; req_large = lg; hash_mask = m;
    base = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat, base, nrd;
    bit ok;
    logic [RW-1:0] er;
    clear_mem();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !hit && !miss && !mem_req, "R1", "outputs during reset",
          {done, hit, miss, mem_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !hit && !miss && !mem_req, "R1", "outputs after reset",
          {done, hit, miss, mem_req}, 0);

    // table walk: R2/R3 addressing, R4 order, R7 result, R8 miss, R10 read count
    for (int i = 0; i < NV; i++) begin
      clear_mem();
      er = RW'(TV_VPN[i]) + RW'(i);
      if (TV_POS[i] < 16)
        put(TV_VPN[i], TV_LARGE[i], TV_MASK[i], TV_POS[i], er, TV_POS[i][2], TV_POS[i][1:0]);
      else  // R5: wrong hash identifier in the primary group must not match
        mem[loc(TV_VPN[i], TV_LARGE[i], TV_MASK[i], 4)] =
          mk_ent(TV_VPN[i][63:7], TV_LARGE[i], 1'b1, 1'b1, er, 1'b0, 2'b01);
      search(TV_VPN[i], TV_LARGE[i], TV_MASK[i], lat, base);
      if (TV_POS[i] < 16) begin
        check(done && hit && !miss, "R7", $sformatf("v%0d hit flags", i), {done, hit, miss}, 3'b110);
        check(slot == TV_POS[i][2:0] && sec == (TV_POS[i] >= 8), "R7",
              $sformatf("v%0d slot/sec", i), {sec, slot}, TV_POS[i]);
        check(rpn == er && pp == TV_POS[i][1:0] && nx == TV_POS[i][2], "R7",
              $sformatf("v%0d rpn", i), {rpn, pp, nx}, {er, TV_POS[i][1:0], TV_POS[i][2]});
        check(lat == TV_POS[i] + 2, "R7", $sformatf("v%0d latency", i), lat, TV_POS[i] + 2);
      end else begin
        check(done && miss && !hit, "R8", $sformatf("v%0d miss flags", i), {done, hit, miss}, 3'b101);
        check(lat == 17, "R8", $sformatf("v%0d miss latency", i), lat, 17);
      end
      nrd = rd_cnt - base;
      check(nrd == ((TV_POS[i] < 16) ? TV_POS[i] + 1 : 16), "R10",
            $sformatf("v%0d read count", i), nrd, (TV_POS[i] < 16) ? TV_POS[i] + 1 : 16);
      ok = 1'b1;
      for (int j = 0; j < nrd && j < 16; j++)
        if (rd_log[(base + j) % 64] != loc(TV_VPN[i], TV_LARGE[i], TV_MASK[i], j)) ok = 1'b0;
      check(ok, TV_LARGE[i] ? "R3" : "R2", $sformatf("v%0d address sequence (R4)", i),
            rd_log[base % 64], loc(TV_VPN[i], TV_LARGE[i], TV_MASK[i], 0));
      @(negedge clk);
      check(!done, "R7", $sformatf("v%0d done width", i), done, 0);
    end

    // R5: one-field decoys ahead of the real match
    begin
      logic [63:0] v;
      v = 64'h0000_0ABC_DEF0_1357;
      clear_mem();
      mem[loc(v, 0, 6'h3F, 0)] = mk_ent(v[63:7], 0, 0, 0, 50'h1, 0, 0);
      mem[loc(v, 0, 6'h3F, 1)] = mk_ent(v[63:7], 0, 1, 1, 50'h2, 0, 0);
      mem[loc(v, 0, 6'h3F, 2)] = mk_ent(v[63:7], 1, 0, 1, 50'h3, 0, 0);
      mem[loc(v, 0, 6'h3F, 3)] = mk_ent(v[63:7] ^ 57'h1, 0, 0, 1, 50'h4, 0, 0);
      mem[loc(v, 0, 6'h3F, 8)] = mk_ent(v[63:7], 0, 0, 1, 50'h5, 0, 0);
      mem[loc(v, 0, 6'h3F, 9)] = mk_ent(v[63:7] ^ (57'h1 << 56), 0, 1, 1, 50'h6, 0, 0);
      put(v, 0, 6'h3F, 10, 50'h2_ABCD, 1'b1, 2'b10);
      search(v, 0, 6'h3F, lat, base);
      check(hit && sec && slot == 3'd2, "R5", "decoys skipped", {hit, sec, slot}, 5'b11010);
      check(rpn == 50'h2_ABCD && pp == 2'b10 && nx, "R5", "decoy result fields", rpn, 50'h2_ABCD);
      @(negedge clk);
    end

    // R6: first match in read order wins
    begin
      logic [63:0] v;
      v = 64'h0000_0000_5555_AAAA;
      clear_mem();
      put(v, 0, 6'h3F, 6, 50'h66, 0, 2'b11);
      put(v, 0, 6'h3F, 5, 50'h55, 0, 2'b01);
      put(v, 0, 6'h3F, 8, 50'h88, 0, 2'b00);
      search(v, 0, 6'h3F, lat, base);
      check(hit && !sec && slot == 3'd5 && rpn == 50'h55, "R6", "lowest slot wins",
            {sec, slot}, 4'd5);
      @(negedge clk);
    end

    // R9: a request during a search is ignored
    begin
      logic [63:0] va, vb;
      va = 64'h0000_0000_0012_3450;
      vb = 64'h0000_0000_0045_6780;
      clear_mem();
      put(va, 0, 6'h3F, 14, 50'hA_AAAA, 0, 2'b10);
      put(vb, 0, 6'h3F, 0, 50'hB_BBBB, 1'b1, 2'b01);
      @(negedge clk);
      req_valid = 1'b1; req_vpn = va; req_large = 1'b0; hash_mask = 6'h3F;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_vpn = vb;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
        @(negedge clk);
        lat++;
      end
      check(hit && sec && slot == 3'd6 && rpn == 50'hA_AAAA, "R9", "first search result kept",
            rpn, 50'hA_AAAA);
      repeat (2) @(negedge clk);
      check(!done && !mem_req, "R9", "no second search started", {done, mem_req}, 0);
      search(vb, 0, 6'h3F, lat, base);
      check(hit && !sec && slot == 3'd0 && rpn == 50'hB_BBBB, "R9", "ignored request alone",
            rpn, 50'hB_BBBB);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule